// File: doc/BRIEF.md
# 24-Hour Alarm Clock

This block keeps the time of day from a slow 10 Hz base clock. It shows hours, minutes and seconds as six decimal digits, and the hour runs from 00 to 23. A small divider turns the base clock into a one-second step. A chain of three tens/units counter pairs (seconds, minutes, hours) advances on each step and carries from one pair to the next.

Four decimal digit inputs supply an hour and a minute. There are two separate load strobes: one copies the inputs into the running time, and the other copies them into the alarm register. The alarm second is always 00, so a match occurs once per day, at the first second of the chosen minute. An alarm state machine has three states. ARMED is the idle state. RINGING drives the alarm output high. SILENCED is entered after a stop or after the enable is removed, and it waits for the match to end. The transitions are:
- ARMED to RINGING on match with enable high and stop low.
- RINGING to SILENCED on stop, or when the enable goes low.
- SILENCED to ARMED once the match has ended.

Every digit is a 4-bit unsigned binary value.

Top module: `alarm_clock24`

## Requirements
- R1: Hours stay within 00 to 23. The minute and second tens digits stay within 0 to 5. Every units digit stays within 0 to 9.
- R2: With the default of 10 base cycles per second, the seconds advance by one on the 10th rising edge after a time load or reset edge, and then once every 10 edges.
- R3: A units digit carries into its tens digit after 9. Seconds carry into minutes after 59, and minutes carry into hours after 59. The time 23:59:59 is followed by 00:00:00.
- R4: The reset is synchronous and active high. It loads both the time and the alarm from the digit inputs, clears the seconds, restarts the divider and returns the state machine to ARMED, so the alarm output is low. If the digits are illegal during reset, both the time and the alarm become 00:00.
- R5: While the time-load input is high and the digits are legal, the hours and minutes take the input digits, the seconds read 00 and the divider is held at its start. Counting resumes from there when the input drops. Reset has priority over the time load.
- R6: An alarm-load edge with legal digits stores the alarm hour and minute, and the alarm second is fixed at 00. It leaves the running time and the divider undisturbed.
- R7: A load is ignored entirely if the hour tens digit is above 2, the hour is above 23, the minute tens digit is above 5, or any digit is above 9. This applies to both the time load and the alarm load. The target register keeps its value and the time keeps running.
- R8: In ARMED, with the enable high and stop low, the alarm output rises one cycle after the displayed time equals the alarm hour, the alarm minute and second 00.
- R9: Once RINGING, the alarm output stays high after the match has passed. It stays high until stop is asserted or the enable is removed.
- R10: Stop drives the alarm low on the next edge. The alarm does not ring again during the rest of the matching second, and it is ARMED again once the match ends.
- R11: With the enable low, the alarm output is low on the next edge. If the enable is low when the match begins, there is no ring during that matching second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 Hz base clock |
| rst | input | 1 | Synchronous active-high reset that loads time and alarm |
| hr_tens_in | input | 4 | Hour tens digit to load |
| hr_ones_in | input | 4 | Hour units digit to load |
| mn_tens_in | input | 4 | Minute tens digit to load |
| mn_ones_in | input | 4 | Minute units digit to load |
| load_time | input | 1 | Copy digit inputs into the running time |
| load_alarm | input | 1 | Copy digit inputs into the alarm register |
| alarm_enable | input | 1 | Allows the alarm to ring |
| alarm_stop | input | 1 | Silences a ringing alarm |
| alarm | output | 1 | High while the alarm state machine is RINGING |
| hr_tens | output | 4 | Current hour tens digit |
| hr_ones | output | 4 | Current hour units digit |
| mn_tens | output | 4 | Current minute tens digit |
| mn_ones | output | 4 | Current minute units digit |
| sc_tens | output | 4 | Current second tens digit |
| sc_ones | output | 4 | Current second units digit |

## Verification
The properties assume that the digit inputs, the load strobes, the enable and stop are steady around each rising edge. They also assume that reset is asserted before any check matters, because the checker stays inactive until it has seen a reset. The stimulus changes every input only at falling edges. It holds reset for the first edges, and it keeps the loads to a single edge except where holding a load is itself under test. Illegal digit patterns come only through the normal load strobes, so the range property on the displayed digits depends only on the design rejecting them.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int DIGIT_W = 4;
    localparam int STAGES  = 3;   // seconds, minutes, hours

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t ones;
    } pair_t;

    typedef struct packed {
        pair_t hr;
        pair_t mn;
    } hhmm_t;

    typedef enum logic [1:0] {
        ALM_ARMED    = 2'd0,
        ALM_RINGING  = 2'd1,
        ALM_SILENCED = 2'd2
    } alm_state_e;

    localparam bcd_t UNITS_MAX = bcd_t'(9);
    localparam bcd_t SIXTY_TENS_MAX = bcd_t'(5);

    // last value of a counter pair before it wraps to 00
    function automatic pair_t stage_last(int idx);
        pair_t p;
        if (idx == STAGES - 1) begin
            p.tens = bcd_t'(2);
            p.ones = bcd_t'(3);
        end else begin
            p.tens = SIXTY_TENS_MAX;
            p.ones = UNITS_MAX;
        end
        return p;
    endfunction

    function automatic pair_t pair_inc(pair_t p, pair_t last);
        pair_t n;
        if (p == last) begin
            n = '0;
        end else if (p.ones == UNITS_MAX) begin
            n.tens = bcd_t'(p.tens + bcd_t'(1));
            n.ones = '0;
        end else begin
            n.tens = p.tens;
            n.ones = bcd_t'(p.ones + bcd_t'(1));
        end
        return n;
    endfunction

    function automatic logic hhmm_legal(hhmm_t v);
        logic [7:0] hours;
        hours = {4'd0, v.hr.tens} * 8'd10 + {4'd0, v.hr.ones};
        return (v.hr.tens <= bcd_t'(2)) && (v.hr.ones <= UNITS_MAX) &&
               (hours <= 8'd23) && (v.mn.tens <= SIXTY_TENS_MAX) &&
               (v.mn.ones <= UNITS_MAX);
    endfunction

endpackage

// File: rtl/aclk_prescaler.sv
module aclk_prescaler #(
    parameter int TICKS_PER_SEC = 10
) (
    input  logic clk,
    input  logic restart,
    output logic sec_tick
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sec_tick = (cnt == LAST) && !restart;

endmodule

// File: rtl/aclk_timekeeper.sv
module aclk_timekeeper
    import aclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  logic  load_ok,
    input  hhmm_t load_val,
    input  logic  sec_tick,
    output pair_t sec_now,
    output pair_t min_now,
    output pair_t hr_now
);
    pair_t               cur       [STAGES];
    pair_t               load_pair [STAGES];
    logic [STAGES:0]     carry;

    assign load_pair[0] = '0;
    assign load_pair[1] = load_val.mn;
    assign load_pair[2] = load_val.hr;
    assign carry[0]     = sec_tick;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam pair_t LAST = stage_last(g);

        assign carry[g+1] = carry[g] && (cur[g] == LAST);

        always_ff @(posedge clk) begin
            if (rst) begin
                cur[g] <= load_ok ? load_pair[g] : '0;
            end else if (load_en && load_ok) begin
                cur[g] <= load_pair[g];
            end else if (carry[g]) begin
                cur[g] <= pair_inc(cur[g], LAST);
            end
        end
    end

    assign sec_now = cur[0];
    assign min_now = cur[1];
    assign hr_now  = cur[2];

endmodule

// File: rtl/aclk_alarm.sv
module aclk_alarm
    import aclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  logic  load_ok,
    input  hhmm_t load_val,
    input  hhmm_t now_hm,
    input  pair_t now_sec,
    input  logic  enable,
    input  logic  stop,
    output logic  ringing
);
    hhmm_t      alm_hm;
    alm_state_e state, nxt;
    logic       match;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_hm <= load_ok ? load_val : '0;
        end else if (load_en && load_ok) begin
            alm_hm <= load_val;
        end
    end

    assign match = (now_hm == alm_hm) && (now_sec == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ALM_ARMED;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ALM_ARMED:    if (enable && match && !stop) nxt = ALM_RINGING;
            ALM_RINGING:  if (stop || !enable)          nxt = ALM_SILENCED;
            ALM_SILENCED: if (!match)                   nxt = ALM_ARMED;
            default:                                    nxt = ALM_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        ringing = (state == ALM_RINGING);
    end

endmodule

// File: rtl/alarm_clock24.sv
module alarm_clock24
    import aclk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] hr_tens_in,
    input  logic [DIGIT_W-1:0] hr_ones_in,
    input  logic [DIGIT_W-1:0] mn_tens_in,
    input  logic [DIGIT_W-1:0] mn_ones_in,
    input  logic               load_time,
    input  logic               load_alarm,
    input  logic               alarm_enable,
    input  logic               alarm_stop,
    output logic               alarm,
    output logic [DIGIT_W-1:0] hr_tens,
    output logic [DIGIT_W-1:0] hr_ones,
    output logic [DIGIT_W-1:0] mn_tens,
    output logic [DIGIT_W-1:0] mn_ones,
    output logic [DIGIT_W-1:0] sc_tens,
    output logic [DIGIT_W-1:0] sc_ones
);
    hhmm_t digits_in;
    hhmm_t now_hm;
    pair_t sec_now, min_now, hr_now;
    logic  digits_ok;
    logic  restart;
    logic  sec_tick;

    assign digits_in = '{hr: '{tens: hr_tens_in, ones: hr_ones_in},
                         mn: '{tens: mn_tens_in, ones: mn_ones_in}};
    assign digits_ok = hhmm_legal(digits_in);
    assign restart   = rst || (load_time && digits_ok);

    aclk_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk      (clk),
        .restart  (restart),
        .sec_tick (sec_tick)
    );

    aclk_timekeeper u_time (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_time),
        .load_ok  (digits_ok),
        .load_val (digits_in),
        .sec_tick (sec_tick),
        .sec_now  (sec_now),
        .min_now  (min_now),
        .hr_now   (hr_now)
    );

    assign now_hm = '{hr: hr_now, mn: min_now};

    aclk_alarm u_alm (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_alarm),
        .load_ok  (digits_ok),
        .load_val (digits_in),
        .now_hm   (now_hm),
        .now_sec  (sec_now),
        .enable   (alarm_enable),
        .stop     (alarm_stop),
        .ringing  (alarm)
    );

    assign hr_tens = hr_now.tens;
    assign hr_ones = hr_now.ones;
    assign mn_tens = min_now.tens;
    assign mn_ones = min_now.ones;
    assign sc_tens = sec_now.tens;
    assign sc_ones = sec_now.ones;

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker
    import aclk_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic [3:0]   hr_tens_in,
    input logic [3:0]   hr_ones_in,
    input logic [3:0]   mn_tens_in,
    input logic [3:0]   mn_ones_in,
    input logic         load_time,
    input logic         alarm_enable,
    input logic         alarm_stop,
    input logic         alarm,
    input logic [3:0]   hr_tens,
    input logic [3:0]   hr_ones,
    input logic [3:0]   mn_tens,
    input logic [3:0]   mn_ones,
    input logic [3:0]   sc_tens,
    input logic [3:0]   sc_ones
);
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b1;
    end

    logic [7:0] hours_shown;
    logic       in_legal;
    assign hours_shown = {4'd0, hr_tens} * 8'd10 + {4'd0, hr_ones};
    assign in_legal    = hhmm_legal('{hr: '{tens: hr_tens_in, ones: hr_ones_in},
                                      mn: '{tens: mn_tens_in, ones: mn_ones_in}});

    assert_digit_range_R1: assert property (@(posedge clk) disable iff (rst || !primed)
        (hours_shown <= 8'd23) && (mn_tens <= 4'd5) && (mn_ones <= 4'd9) &&
        (sc_tens <= 4'd5) && (sc_ones <= 4'd9));

    assert_time_load_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        (load_time && in_legal) |=>
            (hr_tens == $past(hr_tens_in)) && (hr_ones == $past(hr_ones_in)) &&
            (mn_tens == $past(mn_tens_in)) && (mn_ones == $past(mn_ones_in)) &&
            (sc_tens == 4'd0) && (sc_ones == 4'd0));

    assert_rise_on_match_R8: assert property (@(posedge clk) disable iff (rst || !primed)
        $rose(alarm) |-> ($past(alarm_enable) && !$past(alarm_stop) &&
                          $past(sc_tens) == 4'd0 && $past(sc_ones) == 4'd0));

    assert_stop_quiets_R10: assert property (@(posedge clk) disable iff (rst || !primed)
        alarm_stop |=> !alarm);

    assert_enable_gate_R11: assert property (@(posedge clk) disable iff (rst || !primed)
        !alarm_enable |=> !alarm);

endmodule

bind alarm_clock24 aclk_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .hr_tens_in   (hr_tens_in),
    .hr_ones_in   (hr_ones_in),
    .mn_tens_in   (mn_tens_in),
    .mn_ones_in   (mn_ones_in),
    .load_time    (load_time),
    .alarm_enable (alarm_enable),
    .alarm_stop   (alarm_stop),
    .alarm        (alarm),
    .hr_tens      (hr_tens),
    .hr_ones      (hr_ones),
    .mn_tens      (mn_tens),
    .mn_ones      (mn_ones),
    .sc_tens      (sc_tens),
    .sc_ones      (sc_ones)
);

// File: tb/sim_alarm_clock24.sv
module sim_alarm_clock24;
    localparam int TPS = 10;
    localparam int DAY = 86400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] d_h1 = '0, d_h0 = '0, d_m1 = '0, d_m0 = '0;
    logic       ld_t = 1'b0, ld_a = 1'b0, en = 1'b0, stp = 1'b0;
    logic       alarm;
    logic [3:0] ho1, ho0, mo1, mo0, so1, so0;

    int vecs = 0;
    int miss = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_clock24 #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst(rst),
        .hr_tens_in(d_h1), .hr_ones_in(d_h0), .mn_tens_in(d_m1), .mn_ones_in(d_m0),
        .load_time(ld_t), .load_alarm(ld_a), .alarm_enable(en), .alarm_stop(stp),
        .alarm(alarm), .hr_tens(ho1), .hr_ones(ho0), .mn_tens(mo1), .mn_ones(mo0),
        .sc_tens(so1), .sc_ones(so0)
    );

    task automatic wait_edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_time(string req, int total);
        int t;
        logic [23:0] exp_d, act_d;
        t = total % DAY;
        exp_d = {4'(t / 36000), 4'((t / 3600) % 10), 4'((t / 600) % 6),
                 4'((t / 60) % 10), 4'((t / 10) % 6), 4'(t % 10)};
        act_d = {ho1, ho0, mo1, mo0, so1, so0};
        vecs++;
        if (act_d !== exp_d) begin
            miss++;
            $display("FAIL %s time act=%h exp=%h", req, act_d, exp_d);
        end
    endtask

    task automatic chk_alarm(string req, logic exp_a);
        vecs++;
        if (alarm !== exp_a) begin
            miss++;
            $display("FAIL %s alarm act=%b exp=%b", req, alarm, exp_a);
        end
    endtask

    task automatic set_raw(int a, int b, int c, int d);
        d_h1 = 4'(a); d_h0 = 4'(b); d_m1 = 4'(c); d_m0 = 4'(d);
    endtask

    task automatic set_hm(int h, int m);
        set_raw(h / 10, h % 10, m / 10, m % 10);
    endtask

    task automatic load_time_raw(int a, int b, int c, int d);
        set_raw(a, b, c, d);
        ld_t = 1'b1;
        @(negedge clk);
        ld_t = 1'b0;
    endtask

    task automatic load_alarm_raw(int a, int b, int c, int d);
        set_raw(a, b, c, d);
        ld_a = 1'b1;
        @(negedge clk);
        ld_a = 1'b0;
    endtask

    task automatic stop_pulse();
        stp = 1'b1;
        @(negedge clk);
        stp = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            miss++;
            $display("FAIL watchdog run did not complete act=hung exp=done");
            report();
        end
    end

    initial begin
        int base;
        // R4: reset loads 12:34 as time and alarm
        set_hm(12, 34);
        wait_edges(2);
        rst = 1'b0;
        base = 12 * 3600 + 34 * 60;
        chk_time("R4", base);
        chk_alarm("R4", 1'b0);
        // R2: first step on the 10th edge, then every 10
        for (int k = 1; k <= 25; k++) begin
            wait_edges(1);
            chk_time("R2", base + k / TPS);
        end

        // R4: illegal digits during reset give 00:00
        set_raw(3, 0, 0, 0);
        rst = 1'b1;
        wait_edges(1);
        rst = 1'b0;
        chk_time("R4", 0);

        // R3: every hour carry, including 23:59:59 -> 00:00:00
        for (int h = 0; h < 24; h++) begin
            load_time_raw(h / 10, h % 10, 5, 9);
            wait_edges(599);
            chk_time("R3", h * 3600 + 59 * 60 + 59);
            wait_edges(1);
            chk_time("R3", h * 3600 + 3600);
        end
        // R3: minute units into tens
        load_time_raw(1, 0, 0, 9);
        wait_edges(600);
        chk_time("R3", 10 * 3600 + 10 * 60);

        // R5: every legal minute value with varied hours
        for (int m = 0; m < 60; m++) begin
            int h;
            h = (m * 7) % 24;
            load_time_raw(h / 10, h % 10, m / 10, m % 10);
            chk_time("R5", h * 3600 + m * 60);
            wait_edges(9);
            chk_time("R5", h * 3600 + m * 60);
            wait_edges(1);
            chk_time("R5", h * 3600 + m * 60 + 1);
        end
        // R5: holding the load freezes the time at hh:mm:00
        set_hm(8, 15);
        ld_t = 1'b1;
        wait_edges(15);
        chk_time("R5", 8 * 3600 + 15 * 60);
        ld_t = 1'b0;
        wait_edges(10);
        chk_time("R5", 8 * 3600 + 15 * 60 + 1);

        // R7: illegal time loads change nothing, divider not restarted
        for (int p = 0; p < 5; p++) begin
            load_time_raw(0, 5, 0, 0);
            wait_edges(3);
            case (p)
                0: load_time_raw(3, 0, 0, 0);
                1: load_time_raw(2, 4, 0, 0);
                2: load_time_raw(1, 0, 6, 0);
                3: load_time_raw(0, 10, 0, 0);
                default: load_time_raw(0, 0, 0, 15);
            endcase
            wait_edges(21);
            chk_time("R7", 5 * 3600 + 2);
        end

        // R6/R8/R9/R10: alarm at 07:30
        en = 1'b1;
        load_time_raw(0, 7, 2, 9);
        load_alarm_raw(0, 7, 3, 0);
        base = 7 * 3600 + 29 * 60;
        chk_time("R6", base);
        chk_alarm("R6", 1'b0);
        wait_edges(14);
        chk_time("R6", base + 1);
        wait_edges(585);
        chk_time("R8", base + 60);
        chk_alarm("R8", 1'b0);
        wait_edges(1);
        chk_alarm("R8", 1'b1);
        wait_edges(699);
        chk_time("R9", base + 130);
        chk_alarm("R9", 1'b1);
        stop_pulse();
        chk_alarm("R10", 1'b0);
        wait_edges(20);
        chk_alarm("R10", 1'b0);

        // R10: stop during the matching second, no re-ring
        load_time_raw(0, 7, 3, 0);
        wait_edges(1);
        chk_alarm("R8", 1'b1);
        stop_pulse();
        chk_alarm("R10", 1'b0);
        wait_edges(5);
        chk_alarm("R10", 1'b0);
        wait_edges(30);
        chk_alarm("R10", 1'b0);

        // R11: enable removal and enable low at match
        load_time_raw(0, 7, 3, 0);
        wait_edges(1);
        chk_alarm("R11", 1'b1);
        en = 1'b0;
        wait_edges(1);
        chk_alarm("R11", 1'b0);
        wait_edges(20);
        load_time_raw(0, 7, 3, 0);
        wait_edges(5);
        chk_alarm("R11", 1'b0);
        wait_edges(10);
        en = 1'b1;
        wait_edges(5);
        chk_alarm("R11", 1'b0);

        // R7: illegal alarm load keeps 07:30
        load_alarm_raw(2, 5, 0, 0);
        load_alarm_raw(0, 12, 3, 0);
        load_time_raw(0, 7, 3, 0);
        wait_edges(1);
        chk_alarm("R7", 1'b1);
        stop_pulse();

        // R4: reset quiets the alarm and reloads it
        en = 1'b0;
        set_hm(9, 0);
        rst = 1'b1;
        wait_edges(1);
        rst = 1'b0;
        chk_alarm("R4", 1'b0);
        chk_time("R4", 9 * 3600);
        en = 1'b1;
        wait_edges(1);
        chk_alarm("R4", 1'b1);

        done = 1'b1;
        report();
    end

endmodule